// File: doc/BRIEF.md
# Boot and User Program Memory Selector

This block routes each 16-bit program fetch to one of three memories: a 1 KB boot ROM, a 32 KB internal user flash, or external program memory. It holds a two-bit bank-select value. When that value is 00, the whole 64 KB space is user memory. When it is 01, the top 1 KB window (FC00H to FFFFH) is taken over by the boot ROM. A return instruction that goes from that window down to an address below FC00H clears the bank value, so the full user map comes back without any action by software.

Three strap pins are sampled while reset is held. If PSEN is low, EA is low and ALE is high, the block comes out of reset in boot mode: the bank value is 01 and the first fetch goes to FC00H. With any other strap combination the bank value is 00 and the first fetch goes to 0000H. The EA strap is latched at reset and decides the user layout until the next reset. With EA high, internal flash covers 0000H to 7FFFH and external memory covers the rest. With EA low, the whole user space is external.

Software writes the bank value through a write strobe. A write is refused while the instruction being executed sits in the top window of user memory. A refused write sets a sticky fault flag.

Top module: `prog_mem_selector`

## Requirements
- R1: While bank_sel is 00, no fetch address selects the boot ROM; every valid fetch selects flash or external memory.
- R2: While bank_sel is 01, a valid fetch at or above FC00H selects the boot ROM, and a fetch below FC00H selects user memory, as set out in R4.
- R3: After a reset with strap_psen_n=0, strap_ea=0 and strap_ale=1, bank_sel is 01 and start_addr is FC00H. After a reset with any other strap combination, bank_sel is 00 and start_addr is 0000H. bank_fault is 0 after every reset.
- R4: For a fetch that goes to user memory, an EA strap that was high at reset selects flash below 8000H and external memory from 8000H upward. An EA strap that was low at reset selects external memory everywhere. Changing strap_ea after reset has no effect.
- R5: sel_boot, sel_flash and sel_ext are one-hot in the same cycle as a valid fetch. All three are 0 when fetch_valid is low.
- R6: A bank write (bank_wr=1) is accepted when the previous valid fetch was either below FC00H or went to the boot ROM. bank_sel then equals bank_wdata from the next cycle on.
- R7: A valid fetch with xfer_ret=1 at an address below FC00H clears bank_sel to 00 when the previous valid fetch was at or above FC00H.
- R8: A bank write is ignored, and bank_fault goes to 1, when the previous valid fetch was a user-memory fetch at or above FC00H. bank_fault stays 1 until reset.
- R9: A jump or call, and a return that does not cross from at or above FC00H to below it, leave bank_sel unchanged.
- R10: When a crossing return (R7) and an accepted bank write fall in the same cycle, the return wins and bank_sel becomes 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| strap_psen_n | input | 1 | PSEN strap level |
| strap_ea | input | 1 | EA strap level |
| strap_ale | input | 1 | ALE strap level |
| fetch_valid | input | 1 | A program fetch is presented this cycle |
| fetch_addr | input | 16 | Program fetch address |
| xfer_jump | input | 1 | This fetch is the target of a jump or call |
| xfer_ret | input | 1 | This fetch is the target of a return |
| bank_wr | input | 1 | Write strobe for the bank-select value |
| bank_wdata | input | 2 | Value to write to the bank-select bits |
| sel_boot | output | 1 | Fetch goes to the boot ROM |
| sel_flash | output | 1 | Fetch goes to the internal user flash |
| sel_ext | output | 1 | Fetch goes to external program memory |
| bank_sel | output | 2 | Current bank-select bits |
| bank_fault | output | 1 | Sticky flag: a bank write was refused |
| start_addr | output | 16 | Address of the first fetch after reset |

## Verification
The three select outputs are combinational. They are due in the same cycle as the fetch, so the bench drives each fetch on the falling edge and reads the selects one time unit later, before the next rising edge. bank_sel and bank_fault are registered and change one rising edge after the write or return that causes them. The bench therefore reads them on the following falling edge, after it has made the bus idle, so no extra edge can slip in between. The guard on a write depends on the fetch registered in the previous cycle, so every write or return in the bench is preceded by a deliberate setup fetch. Reset values and start_addr are read on the falling edge where reset is released.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    MSEL_NONE  = 3'b000,
    MSEL_EXT   = 3'b001,
    MSEL_FLASH = 3'b010,
    MSEL_BOOT  = 3'b100
  } msel_e;

  localparam logic [1:0] BANK_USER  = 2'b00;
  localparam logic [1:0] BANK_SPLIT = 2'b01;

  // Address is at or above a window base.
  function automatic logic addr_at_or_above(input int unsigned addr, input int unsigned base);
    return addr >= base;
  endfunction

  // Strap combination that requests a boot-ROM start.
  function automatic logic strap_wants_boot(input logic psen_n, input logic ea, input logic ale);
    return (!psen_n) && (!ea) && ale;
  endfunction

endpackage

// File: rtl/pms_strap.sv
module pms_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_psen_n,
  input  logic strap_ea,
  input  logic strap_ale,
  output logic boot_now,
  output logic boot_q,
  output logic ea_q
);
  import pms_pkg::*;

  assign boot_now = strap_wants_boot(strap_psen_n, strap_ea, strap_ale);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_q   <= strap_ea;
      boot_q <= boot_now;
    end
  end

endmodule

// File: rtl/pms_decode.sv
module pms_decode #(
  parameter int ADDR_W    = 16,
  parameter int BOOT_BASE = 'hFC00,
  parameter int FLASH_TOP = 'h8000
) (
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [1:0]        bank,
  input  logic              ea_int,
  output logic              in_top,
  output pms_pkg::msel_e    sel
);
  import pms_pkg::*;

  logic in_flash_range;

  assign in_top         = addr_at_or_above(int'(fetch_addr), BOOT_BASE);
  assign in_flash_range = !addr_at_or_above(int'(fetch_addr), FLASH_TOP);

  always_comb begin
    if (!fetch_valid)                        sel = MSEL_NONE;
    else if (bank == BANK_SPLIT && in_top)   sel = MSEL_BOOT;
    else if (ea_int && in_flash_range)       sel = MSEL_FLASH;
    else                                     sel = MSEL_EXT;
  end

  // R5
  always_comb begin
    if (fetch_valid) begin
      sel_onehot_chk: assert ($onehot(sel));
    end
  end

endmodule

// File: rtl/pms_bank_ctl.sv
module pms_bank_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boot_now,
  input  logic       fetch_valid,
  input  logic       fetch_top,
  input  logic       fetch_boot,
  input  logic       xfer_ret,
  input  logic       bank_wr,
  input  logic [1:0] bank_wdata,
  output logic [1:0] bank,
  output logic       fault,
  output logic       ret_cross,
  output logic       wr_blocked
);
  import pms_pkg::*;

  logic last_top;
  logic last_user_top;
  logic wr_taken;

  assign ret_cross  = fetch_valid && xfer_ret && last_top && !fetch_top;
  assign wr_blocked = bank_wr && last_user_top;
  assign wr_taken   = bank_wr && !last_user_top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank          <= boot_now ? BANK_SPLIT : BANK_USER;
      fault         <= 1'b0;
      last_top      <= 1'b0;
      last_user_top <= 1'b0;
    end else begin
      if (ret_cross)     bank <= BANK_USER;
      else if (wr_taken) bank <= bank_wdata;
      if (wr_blocked)    fault <= 1'b1;
      if (fetch_valid) begin
        last_top      <= fetch_top;
        last_user_top <= fetch_top && !fetch_boot;
      end
    end
  end

  // R7
  ret_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_cross |=> (bank == BANK_USER));

  // R8
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  // R8
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_blocked && !ret_cross) |=> $stable(bank));

  // R6
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_taken && !ret_cross) |=> (bank == $past(bank_wdata)));

endmodule

// File: rtl/prog_mem_selector.sv
module prog_mem_selector #(
  parameter int ADDR_W    = 16,
  parameter int BOOT_BASE = 'hFC00,
  parameter int FLASH_TOP = 'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_psen_n,
  input  logic              strap_ea,
  input  logic              strap_ale,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              xfer_jump,
  input  logic              xfer_ret,
  input  logic              bank_wr,
  input  logic [1:0]        bank_wdata,
  output logic              sel_boot,
  output logic              sel_flash,
  output logic              sel_ext,
  output logic [1:0]        bank_sel,
  output logic              bank_fault,
  output logic [ADDR_W-1:0] start_addr
);
  import pms_pkg::*;

  localparam logic [ADDR_W-1:0] BOOT_VEC = ADDR_W'(BOOT_BASE);

  logic  boot_now, boot_q, ea_q;
  logic  fetch_top;
  logic  ret_cross, wr_blocked;
  msel_e sel;

  pms_strap u_strap (
    .clk(clk), .rst_n(rst_n),
    .strap_psen_n(strap_psen_n), .strap_ea(strap_ea), .strap_ale(strap_ale),
    .boot_now(boot_now), .boot_q(boot_q), .ea_q(ea_q)
  );

  pms_decode #(.ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE), .FLASH_TOP(FLASH_TOP)) u_decode (
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .bank(bank_sel), .ea_int(ea_q), .in_top(fetch_top), .sel(sel)
  );

  pms_bank_ctl u_bank (
    .clk(clk), .rst_n(rst_n), .boot_now(boot_now),
    .fetch_valid(fetch_valid), .fetch_top(fetch_top), .fetch_boot(sel == MSEL_BOOT),
    .xfer_ret(xfer_ret), .bank_wr(bank_wr), .bank_wdata(bank_wdata),
    .bank(bank_sel), .fault(bank_fault),
    .ret_cross(ret_cross), .wr_blocked(wr_blocked)
  );

  assign sel_boot   = (sel == MSEL_BOOT);
  assign sel_flash  = (sel == MSEL_FLASH);
  assign sel_ext    = (sel == MSEL_EXT);
  assign start_addr = boot_q ? BOOT_VEC : '0;

  // R5
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> !(sel_boot || sel_flash || sel_ext));

  // R1
  no_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && bank_sel == BANK_USER) |-> !sel_boot);

  // R9
  jump_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && xfer_jump && !xfer_ret && !bank_wr) |=> $stable(bank_sel));

  // R10
  ret_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_cross && bank_wr) |=> (bank_sel == BANK_USER));

endmodule

// File: tb/prog_mem_selector_tb.sv
module prog_mem_selector_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_psen_n = 1'b1, strap_ea = 1'b1, strap_ale = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        xfer_jump = 1'b0, xfer_ret = 1'b0, bank_wr = 1'b0;
  logic [1:0]  bank_wdata = '0;
  logic        sel_boot, sel_flash, sel_ext, bank_fault;
  logic [1:0]  bank_sel;
  logic [15:0] start_addr;

  int checks = 0;
  int errors = 0;
  logic [1:0] exp_bank;
  logic       exp_ea;
  bit         done = 0;

  always #4 clk = ~clk;

  prog_mem_selector u_dut (
    .clk(clk), .rst_n(rst_n),
    .strap_psen_n(strap_psen_n), .strap_ea(strap_ea), .strap_ale(strap_ale),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .xfer_jump(xfer_jump), .xfer_ret(xfer_ret),
    .bank_wr(bank_wr), .bank_wdata(bank_wdata),
    .sel_boot(sel_boot), .sel_flash(sel_flash), .sel_ext(sel_ext),
    .bank_sel(bank_sel), .bank_fault(bank_fault), .start_addr(start_addr)
  );

  // Expected {boot,flash,ext} from the memory map in the requirements.
  function automatic logic [2:0] exp_sel(input logic [15:0] a, input logic [1:0] b, input logic ea);
    if (b == 2'b01 && a[15:10] == 6'h3F) return 3'b100;
    if (ea && a < 16'd32768)             return 3'b010;
    return 3'b001;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic jmp, input logic ret,
                      input logic wr, input logic [1:0] wd, input string req);
    logic [2:0] got, want;
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a; xfer_jump = jmp; xfer_ret = ret;
    bank_wr = wr; bank_wdata = wd;
    #1;
    got  = {sel_boot, sel_flash, sel_ext};
    want = exp_sel(a, exp_bank, exp_ea);
    check(got == want, req, {13'd0, got, a}, {13'd0, want, a});
  endtask

  task automatic check_state(input logic [1:0] eb, input logic ef, input string req);
    @(negedge clk);
    fetch_valid = 1'b0; xfer_jump = 1'b0; xfer_ret = 1'b0; bank_wr = 1'b0;
    #1;
    check(bank_sel == eb && bank_fault == ef, req, {bank_fault, bank_sel}, {ef, eb});
    check({sel_boot, sel_flash, sel_ext} == 3'b000, "R5 idle", {sel_boot, sel_flash, sel_ext}, 0);
  endtask

  task automatic do_reset(input logic p, input logic e, input logic l,
                          input logic [1:0] eb, input logic [15:0] esa, input string req);
    @(negedge clk);
    rst_n = 1'b0; fetch_valid = 1'b0; bank_wr = 1'b0; xfer_ret = 1'b0; xfer_jump = 1'b0;
    strap_psen_n = p; strap_ea = e; strap_ale = l;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(bank_sel == eb && bank_fault == 1'b0, req, {bank_fault, bank_sel}, {1'b0, eb});
    check(start_addr == esa, req, start_addr, esa);
    exp_bank = eb; exp_ea = e;
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 512; i++) step(16'(i * 128), 1'b0, 1'b0, 1'b0, 2'b00, req);
    step(16'h7FFF, 0, 0, 0, 2'b00, req);
    step(16'h8000, 0, 0, 0, 2'b00, req);
    step(16'hFBFF, 0, 0, 0, 2'b00, req);
    step(16'hFC00, 0, 0, 0, 2'b00, req);
    step(16'hFFFF, 0, 0, 0, 2'b00, req);
    check_state(exp_bank, 1'b0, req);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_bank = 2'b00; exp_ea = 1'b1;
    // R3 normal reset, EA high
    do_reset(1'b1, 1'b1, 1'b1, 2'b00, 16'h0000, "R3 normal");
    // R1 R4 R5 full map with bank 00, EA high
    sweep("R1 R4 bank00 ea1");
    // R4 strap change after reset has no effect
    strap_ea = 1'b0;
    sweep("R4 ea latched");

    // R6 accepted write from low region
    step(16'h0100, 0, 0, 0, 2'b00, "R6 setup");
    step(16'h0102, 0, 0, 1, 2'b01, "R6 write");
    check_state(2'b01, 1'b0, "R6 write taken");
    exp_bank = 2'b01;
    // R2 split map
    sweep("R2 bank01 ea1");

    // R9 jump into window, return within window keep bank
    step(16'h0200, 0, 0, 0, 2'b00, "R9 setup");
    step(16'hFC00, 1, 0, 0, 2'b00, "R9 jump");
    step(16'hFC10, 0, 1, 0, 2'b00, "R9 ret in window");
    check_state(2'b01, 1'b0, "R9 bank kept");
    // R9 return low to low keeps bank
    step(16'h0300, 0, 0, 0, 2'b00, "R9 setup low");
    step(16'h0400, 0, 1, 0, 2'b00, "R9 ret low");
    check_state(2'b01, 1'b0, "R9 low ret kept");
    // R7 return across border clears bank
    step(16'hFD00, 1, 0, 0, 2'b00, "R7 enter");
    step(16'h0500, 0, 1, 0, 2'b00, "R7 ret cross");
    check_state(2'b00, 1'b0, "R7 cleared");
    exp_bank = 2'b00;

    // R8 write from user top window is refused
    step(16'hFD00, 0, 0, 0, 2'b00, "R8 setup");
    step(16'hFD02, 0, 0, 1, 2'b01, "R8 write");
    check_state(2'b00, 1'b1, "R8 refused");
    step(16'h0010, 0, 0, 0, 2'b00, "R8 low");
    step(16'h0012, 0, 0, 1, 2'b01, "R8 later write");
    check_state(2'b01, 1'b1, "R8 sticky, R6 taken");
    exp_bank = 2'b01;

    // R6 write accepted from boot ROM
    step(16'hFC00, 1, 0, 0, 2'b00, "R6 boot setup");
    step(16'hFC02, 0, 0, 1, 2'b00, "R6 boot write");
    check_state(2'b00, 1'b1, "R6 write from boot");
    exp_bank = 2'b00;

    // R10 return crossing beats a write in the same cycle
    step(16'h0020, 0, 0, 0, 2'b00, "R10 setup");
    step(16'h0022, 0, 0, 1, 2'b01, "R10 arm");
    check_state(2'b01, 1'b1, "R10 armed");
    exp_bank = 2'b01;
    step(16'hFC00, 1, 0, 0, 2'b00, "R10 enter");
    step(16'h0300, 0, 1, 1, 2'b01, "R10 ret+write");
    check_state(2'b00, 1'b1, "R10 ret wins");
    exp_bank = 2'b00;

    // R3 boot-strap reset, R4 EA low map, R2 split
    do_reset(1'b0, 1'b0, 1'b1, 2'b01, 16'hFC00, "R3 boot strap");
    sweep("R2 R4 bank01 ea0");
    // R3 near-boot strap combinations stay normal
    do_reset(1'b0, 1'b0, 1'b0, 2'b00, 16'h0000, "R3 ale low");
    do_reset(1'b1, 1'b0, 1'b1, 2'b00, 16'h0000, "R3 psen high");
    sweep("R1 R4 bank00 ea0");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule